// File: doc/BRIEF.md
# Four-Channel DAC Frame Writer

This block turns a stream of bytes into serial write frames for a four-channel serial DAC. Bytes arrive on a valid/ready stream in counted batches. A batch opens with one count byte. That many pairs follow, and each pair is a value byte and then a channel byte. For each pair the block builds one 16-bit frame and shifts it out, MSB first, over a three-wire link. The link has an active-low frame strobe, a serial clock and a data line.

The frame holds four fields, from the top bit down:
- the two-bit channel address;
- a reserved zero bit;
- an update-now flag, which is set to one;
- the eight-bit value, which straddles the byte boundary;
- four zero padding bits.

The serial clock runs at the system clock divided by `2*HALF_DIV`. The strobe stays low across both bytes of a frame. It then stays high for at least one full serial-clock period before the next frame starts.

Two state machines do the work. The batch parser has four states:
- `P_COUNT` waits for a count byte. A zero count stays here; a nonzero count moves to `P_VALUE`.
- `P_VALUE` takes the value byte and moves to `P_CHAN`.
- `P_CHAN` takes the channel byte, starts a frame and moves to `P_WAIT`.
- `P_WAIT` holds the input stalled until the frame is finished. It then moves to `P_VALUE` if pairs remain, or to `P_COUNT` when the batch is done.

The shifter has five states:
- `S_IDLE` waits for a start request and moves to `S_LEAD`.
- `S_LEAD` drops the strobe and allows one half period of setup time, then moves to `S_SHIFT`.
- `S_SHIFT` runs sixteen clock periods, then moves to `S_TRAIL`.
- `S_TRAIL` holds the strobe low for one more half period, then moves to `S_GAP`.
- `S_GAP` holds the strobe high for two half periods and reports the frame as done, then returns to `S_IDLE`.

Top module: `dac4_frame_writer`

## Requirements
- R1: Bits 15:14 of the frame carry the low two bits of the channel byte. Channel-byte bits 7:2 have no effect on the frame.
- R2: Frame bit 13 is 0 and frame bit 12 is 1 (update outputs after the write).
- R3: Frame bits 11:8 carry bits 7:4 of the value byte.
- R4: Frame bits 7:4 carry bits 3:0 of the value byte, and frame bits 3:0 are 0.
- R5: Each frame is sent MSB first during one low period of `spi_sync_n`. That period contains exactly 16 rising edges of `spi_sclk`, and `spi_mosi` is stable while `spi_sclk` is high. `spi_sclk` is low whenever `spi_sync_n` is high.
- R6: Between consecutive frames, `spi_sync_n` stays high for at least `2*HALF_DIV` clock cycles (one serial-clock period).
- R7: A batch is a count byte followed by that many value-then-channel pairs. Frames are emitted in the order the pairs arrive.
- R8: A count byte of 0 produces no serial activity. The byte that follows it is taken as a new count.
- R9: `in_ready` is low for the whole time a frame is in flight. A byte is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R10: After reset, `spi_sync_n` is 1, `spi_sclk` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Byte stream: count, then value/channel pairs |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| spi_sync_n | output | 1 | Active-low frame strobe |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |

## Verification
The case hardest to reach from the ports is a batch boundary that falls directly after a frame ends. Here the parser must decide between `P_VALUE` and `P_COUNT`, and a zero count arriving next must cause no activity at all. The stimulus drives many random batches with counts from one to six, sent back to back. Directed batches are mixed in:
- a zero count followed immediately by a real batch;
- channel bytes with their upper bits set;
- the extreme values 0x00 and 0xFF.

Each frame captured on the serial pins is compared against a queue of expected frames, which checks field placement and ordering together.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
    typedef enum logic [1:0] {
        P_COUNT,
        P_VALUE,
        P_CHAN,
        P_WAIT
    } parse_st_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_SHIFT,
        S_TRAIL,
        S_GAP
    } shift_st_t;
endpackage

// File: rtl/dacw_frame_fmt.sv
module dacw_frame_fmt #(
    parameter int DATA_W  = 8,
    parameter int CH_BITS = 2,
    parameter int PAD_W   = 4,
    localparam int FRAME_W = CH_BITS + 2 + DATA_W + PAD_W
) (
    input  logic [DATA_W-1:0]  value,
    input  logic [CH_BITS-1:0] chan,
    output logic [FRAME_W-1:0] frame
);
    // Channel on top, reserved zero, update-now flag, value, zero pad.
    generate
        if (PAD_W > 0) begin : g_pad
            assign frame = {chan, 1'b0, 1'b1, value, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign frame = {chan, 1'b0, 1'b1, value};
        end
    endgenerate
endmodule

// File: rtl/dacw_batch_parser.sv
module dacw_batch_parser
    import dacw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              frame_done,
    output logic              frame_start,
    output logic [DATA_W-1:0] value_q
);
    parse_st_t   state, state_nx;
    logic [DATA_W-1:0] remain_q;
    logic        take;

    assign take = in_valid && in_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_COUNT;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            P_COUNT: if (take && (in_data != '0)) state_nx = P_VALUE;
            P_VALUE: if (take) state_nx = P_CHAN;
            P_CHAN:  if (take) state_nx = P_WAIT;
            P_WAIT:  if (frame_done)
                         state_nx = (remain_q == DATA_W'(1)) ? P_COUNT : P_VALUE;
            default: state_nx = P_COUNT;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            value_q  <= '0;
        end else begin
            if (state == P_COUNT && take) remain_q <= in_data;
            if (state == P_WAIT && frame_done) remain_q <= remain_q - DATA_W'(1);
            if (state == P_VALUE && take) value_q <= in_data;
        end
    end

    // Outputs
    always_comb begin
        in_ready    = (state != P_WAIT);
        frame_start = (state == P_CHAN) && take;
    end
endmodule

// File: rtl/dacw_spi_shifter.sv
module dacw_spi_shifter
    import dacw_pkg::*;
#(
    parameter int FRAME_W  = 16,
    parameter int HALF_DIV = 2,
    localparam int HC_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
    localparam int BIT_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               done,
    output logic               sync_n,
    output logic               sclk,
    output logic               mosi
);
    shift_st_t state, state_nx;
    logic [HC_W-1:0]    hcnt;
    logic               tick;
    logic [BIT_W-1:0]   bitcnt;
    logic [FRAME_W-1:0] shreg;
    logic               sclk_q;
    logic               gap_half;
    logic               last_bit;

    assign tick     = (hcnt == HC_W'(HALF_DIV - 1));
    assign last_bit = (bitcnt == BIT_W'(FRAME_W - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_LEAD;
            S_LEAD:  if (tick) state_nx = S_SHIFT;
            S_SHIFT: if (tick && sclk_q && last_bit) state_nx = S_TRAIL;
            S_TRAIL: if (tick) state_nx = S_GAP;
            S_GAP:   if (tick && gap_half) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Datapath: divider, shift register, clock phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt     <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            sclk_q   <= 1'b0;
            gap_half <= 1'b0;
        end else begin
            if (state == S_IDLE || tick) hcnt <= '0;
            else                         hcnt <= hcnt + HC_W'(1);

            unique case (state)
                S_IDLE: begin
                    bitcnt   <= '0;
                    gap_half <= 1'b0;
                    sclk_q   <= 1'b0;
                    if (start) shreg <= frame;
                end
                S_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (!last_bit) begin
                                shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                                bitcnt <= bitcnt + BIT_W'(1);
                            end
                        end
                    end
                end
                S_GAP: if (tick) gap_half <= 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sync_n = (state == S_IDLE) || (state == S_GAP);
        sclk   = sclk_q;
        mosi   = shreg[FRAME_W-1];
        done   = (state == S_GAP) && tick && gap_half;
    end
endmodule

// File: rtl/dac4_frame_writer.sv
module dac4_frame_writer #(
    parameter int DATA_W   = 8,
    parameter int CH_BITS  = 2,
    parameter int PAD_W    = 4,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              spi_sync_n,
    output logic              spi_sclk,
    output logic              spi_mosi
);
    localparam int FRAME_W = CH_BITS + 2 + DATA_W + PAD_W;

    logic              start;
    logic              done;
    logic [DATA_W-1:0] value_q;
    logic [FRAME_W-1:0] frame;

    dacw_batch_parser #(.DATA_W(DATA_W)) u_parser (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .frame_done  (done),
        .frame_start (start),
        .value_q     (value_q)
    );

    dacw_frame_fmt #(.DATA_W(DATA_W), .CH_BITS(CH_BITS), .PAD_W(PAD_W)) u_fmt (
        .value (value_q),
        .chan  (in_data[CH_BITS-1:0]),
        .frame (frame)
    );

    dacw_spi_shifter #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .frame  (frame),
        .done   (done),
        .sync_n (spi_sync_n),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi)
    );
endmodule

// File: rtl/dacw_checker.sv
module dacw_checker #(
    parameter int FRAME_W  = 16,
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic spi_sync_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int GC_W    = $clog2(GAP_MIN + 1) + 1;
    localparam int EC_W    = $clog2(FRAME_W + 1) + 1;

    logic            sclk_q;
    logic [EC_W-1:0] edge_cnt;
    logic [GC_W-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            edge_cnt <= '0;
            gap_cnt  <= '1;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_sync_n)                 edge_cnt <= '0;
            else if (spi_sclk && !sclk_q)   edge_cnt <= edge_cnt + EC_W'(1);
            if (!spi_sync_n)                gap_cnt <= '0;
            else if (gap_cnt != '1)         gap_cnt <= gap_cnt + GC_W'(1);
        end
    end

    a_r5_sclk_low_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sync_n |-> !spi_sclk);

    a_r5_mosi_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    a_r5_sixteen_edges: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sync_n) |-> (edge_cnt == EC_W'(FRAME_W)));

    a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sync_n) |-> (gap_cnt >= GC_W'(GAP_MIN)));

    a_r9_stall_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sync_n |-> !in_ready);
endmodule

bind dac4_frame_writer dacw_checker #(.FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .spi_sync_n (spi_sync_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi)
);

// File: tb/dac4_frame_writer_test.sv
module dac4_frame_writer_test;
    localparam int HALF_DIV = 2;
    localparam int FRAME_W  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready, spi_sync_n, spi_sclk, spi_mosi;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];
    bit  mon_en = 1'b0;
    logic [15:0] cap;
    int  cap_bits;
    int  hi_run = 1000;
    bit  ready_bad;
    int  falls = 0;

    always #4 clk = ~clk;

    dac4_frame_writer #(.HALF_DIV(HALF_DIV)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .spi_sync_n(spi_sync_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi)
    );

    function automatic logic [15:0] exp_frame(input logic [7:0] v, input logic [7:0] c);
        return {c[1:0], 1'b0, 1'b1, v[7:4], v[3:0], 4'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serial receiver model
    always @(negedge spi_sync_n) if (mon_en) begin
        cap = '0; cap_bits = 0; ready_bad = 1'b0; falls++;
    end
    always @(posedge spi_sclk) if (mon_en && !spi_sync_n) begin
        cap = {cap[14:0], spi_mosi}; cap_bits++;
    end
    always @(posedge spi_sync_n) if (mon_en) begin
        logic [15:0] e;
        check(cap_bits == FRAME_W, "R5 clock edges per frame", cap_bits, FRAME_W);
        check(!ready_bad, "R9 ready low in frame", ready_bad, 0);
        if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected frame", cap, 0);
        end else begin
            e = exp_q.pop_front();
            check(cap[15:14] == e[15:14], "R1 channel field", cap[15:14], e[15:14]);
            check(cap[13:12] == 2'b01, "R2 flag bits", cap[13:12], 2'b01);
            check(cap[11:8] == e[11:8], "R3 upper nibble", cap[11:8], e[11:8]);
            check(cap[7:0] == e[7:0], "R4 lower nibble and pad", cap[7:0], e[7:0]);
            check(cap == e, "R7 frame order", cap, e);
        end
    end

    // Gap and ready monitor, sampled away from the active edge
    always @(negedge clk) if (mon_en) begin
        if (!spi_sync_n && in_ready) ready_bad = 1'b1;
        if (spi_sync_n) begin
            if (spi_sclk) check(1'b0, "R5 sclk high outside frame", 1, 0);
            hi_run++;
        end else begin
            if (hi_run > 0) check(hi_run >= 2*HALF_DIV, "R6 gap length", hi_run, 2*HALF_DIV);
            hi_run = 0;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        bit acc;
        in_data = b; in_valid = 1'b1;
        forever begin
            acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_pair(input logic [7:0] v, input logic [7:0] c);
        exp_q.push_back(exp_frame(v, c));
        send_byte(v);
        send_byte(c);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !spi_sync_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int f0;
        void'($urandom(32'h00c0ffee));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(spi_sync_n == 1'b1, "R10 sync after reset", spi_sync_n, 1);
        check(spi_sclk == 1'b0, "R10 sclk after reset", spi_sclk, 0);
        check(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
        mon_en = 1'b1;

        // Directed: single pair
        send_byte(8'd1); send_pair(8'hA5, 8'd2); drain();
        // R1: upper channel bits ignored; R3/R4 extremes
        send_byte(8'd2); send_pair(8'hFF, 8'hFF); send_pair(8'h00, 8'hFC); drain();
        // R8: zero count, then immediately a real batch
        f0 = falls;
        send_byte(8'd0);
        repeat (40) @(negedge clk);
        check(falls == f0 && spi_sync_n, "R8 zero count no activity", falls - f0, 0);
        check(in_ready == 1'b1, "R8 ready after zero count", in_ready, 1);
        send_byte(8'd1); send_pair(8'h3C, 8'h41); drain();
        check(falls == f0 + 1, "R8 next byte is count", falls - f0, 1);

        // Random batches
        for (int b = 0; b < 25; b++) begin
            int n;
            n = ($urandom % 6) + 1;
            if (b % 5 == 4) send_byte(8'd0);
            send_byte(8'(n));
            for (int k = 0; k < n; k++) send_pair(8'($urandom), 8'($urandom));
        end
        drain();
        check(exp_q.size() == 0, "R7 all frames emitted", exp_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule